// File: doc/BRIEF.md
# Small-page NAND command sequencer

This block turns one request into the command-latch and address-latch cycles of a small-page NAND flash. A request holds a command byte, an optional column address and an optional page address. The block drives the flash strobes (command latch, address latch, active-low chip enable, active-low write enable) and an 8- or 16-bit output data bus, and it watches the flash ready/busy line.

Before a data-input command it inserts the read-pointer command that points into the right area of the page. The address phase is sized from the configured chip capacity. For read commands that carry a page address, chip enable is held low through the busy period that follows. After the address phase the block waits for ready, with a timeout on that wait for reads. Program and erase commands finish at once, and their status is polled elsewhere.

A request is taken with a valid/ready handshake only while the block is idle. A one-cycle done pulse marks the end of each request.

Top module: `nand_cmd_seq`

## Requirements
- R1: When the command is 0x80 (data input), a pointer command goes out first. If the column is at least PAGE_BYTES, the pointer is 0x50 and PAGE_BYTES is subtracted from the column. If the column is below 256, the pointer is 0x00 and the column is unchanged. Otherwise the pointer is 0x01 and 256 is subtracted from the column.
- R2: Command bytes (the pointer and the command) are latched with nand_cle_o=1 and nand_ale_o=0. Address bytes are latched with nand_ale_o=1 and nand_cle_o=0. The two strobes are never high together, and nand_nwe_o is low only while one of them is high.
- R3: An address phase follows the command only when a column or a page is supplied. It carries, in this order: the column byte (if supplied), page bits 7:0, then page bits 15:8 (if a page is supplied).
- R4: A further address byte carrying page bits 19:16, zero-extended from 4 bits, follows the page bytes only when chip_mib_i is greater than 32.
- R5: With bus16_i=1 the (adjusted) column is shifted right by one before it is sent. In both bus modes the byte is driven on nand_io_o[7:0] and nand_io_o[15:8] is 0.
- R6: For commands 0x00, 0x01 and 0x50 with a page address, nand_nce_o stays low from the second page-address byte until the wait ends. For any other command, nand_nce_o is low only during latch cycles.
- R7: A command that waits for ready samples nand_rb_i (1 = ready) no earlier than TWB_CLKS+1 clocks after the last rising edge of nand_nwe_o. If the device is already ready, done_o rises exactly TWB_CLKS+2 clocks after that edge.
- R8: For reads with a page address, the wait for ready gives up after TIMEOUT_US steps of US_CLKS clocks. done_o then rises TWB_CLKS+2+TIMEOUT_US*US_CLKS clocks after the last rising edge of nand_nwe_o, and chip enable is released.
- R9: Commands 0x10, 0x60, 0xD0, 0x80 and 0x70 end with done_o exactly one clock after the last rising edge of nand_nwe_o, whatever nand_rb_i does.
- R10: Command 0xFF, and reads without a page address, wait for ready with no timeout.
- R11: Each latch cycle has one setup clock with nand_nwe_o high, then WE_LOW_CLKS clocks with nand_nwe_o low, then one hold clock with nand_nwe_o high. Data and strobes stay constant through the cycle, and nand_nce_o is low throughout it.
- R12: After reset, req_ready_o=1, nand_nce_o=1, nand_nwe_o=1, and nand_cle_o=nand_ale_o=0. req_ready_o is high only in idle and drops the clock after a request is accepted. done_o is a single-cycle pulse, followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_cmd_i | input | 8 | Command byte |
| req_col_vld_i | input | 1 | Column address supplied |
| req_col_i | input | COL_W | Column address in bytes |
| req_page_vld_i | input | 1 | Page address supplied |
| req_page_i | input | PAGE_W | Page address |
| bus16_i | input | 1 | 1 = 16-bit flash bus |
| chip_mib_i | input | 16 | Chip capacity in MiB |
| nand_rb_i | input | 1 | Ready/busy, 1 = ready |
| nand_cle_o | output | 1 | Command latch strobe |
| nand_ale_o | output | 1 | Address latch strobe |
| nand_nce_o | output | 1 | Chip enable, active low |
| nand_nwe_o | output | 1 | Write enable, active low |
| nand_io_o | output | DATA_W | Flash data bus, driven value |
| done_o | output | 1 | End-of-request pulse |

## Verification
Every byte takes WE_LOW_CLKS+2 clocks, and the bench timestamps each falling and rising edge of nand_nwe_o at the falling clock edge. Timing results are measured from the last rising edge of write enable. The done pulse is due one clock later for the no-wait commands, TWB_CLKS+2 clocks later for a ready device, and TWB_CLKS+2+TIMEOUT_US*US_CLKS clocks later on timeout. The bench checks those differences exactly, because all outputs come from registers and the sample point is fixed. Chip enable and ready/busy checks are made at fixed offsets inside the busy window, well clear of the tWB interval and of the timeout.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [7:0] CMD_READ0    = 8'h00;
  localparam logic [7:0] CMD_READ1    = 8'h01;
  localparam logic [7:0] CMD_READOOB  = 8'h50;
  localparam logic [7:0] CMD_SEQIN    = 8'h80;
  localparam logic [7:0] CMD_PAGEPROG = 8'h10;
  localparam logic [7:0] CMD_ERASE1   = 8'h60;
  localparam logic [7:0] CMD_ERASE2   = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  // slot order: pointer, command, column, page lo, page mid, page hi
  localparam int NUM_SLOTS = 6;
  localparam int SLOT_PG1  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LATCH, ST_TWB, ST_WAIT, ST_DONE
  } seq_state_e;

  function automatic logic is_read(input logic [7:0] c);
    return (c == CMD_READ0) || (c == CMD_READ1) || (c == CMD_READOOB);
  endfunction

  function automatic logic is_nowait(input logic [7:0] c);
    return (c == CMD_PAGEPROG) || (c == CMD_ERASE1) || (c == CMD_ERASE2) ||
           (c == CMD_SEQIN) || (c == CMD_STATUS);
  endfunction
endpackage

// File: rtl/nand_addr_plan.sv
module nand_addr_plan
  import nand_seq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int PAGE_W     = 20,
  parameter int PAGE_BYTES = 512,
  parameter int BIG_MIB    = 32
) (
  input  logic [7:0]                     cmd_i,
  input  logic                           col_vld_i,
  input  logic [COL_W-1:0]               col_i,
  input  logic                           page_vld_i,
  input  logic [PAGE_W-1:0]              page_i,
  input  logic                           bus16_i,
  input  logic [15:0]                    chip_mib_i,
  output logic [NUM_SLOTS-1:0]           mask_o,
  output logic [NUM_SLOTS-1:0][7:0]      bytes_o,
  output logic                           rd_force_o,
  output logic                           nowait_o
);
  localparam logic [COL_W:0]   PAGE_EXT = (COL_W+1)'(PAGE_BYTES);
  localparam logic [COL_W-1:0] PAGE_C   = COL_W'(PAGE_BYTES);
  localparam logic [COL_W-1:0] HALF_C   = COL_W'(256);

  logic             seqin;
  logic [7:0]       prefix;
  logic [COL_W-1:0] col_adj;
  logic [7:0]       col_byte;

  assign seqin = (cmd_i == CMD_SEQIN);

  always_comb begin
    prefix  = CMD_READ0;
    col_adj = col_i;
    if (seqin) begin
      if ({1'b0, col_i} >= PAGE_EXT) begin
        prefix  = CMD_READOOB;
        col_adj = col_i - PAGE_C;
      end else if (col_i >= HALF_C) begin
        prefix  = CMD_READ1;
        col_adj = col_i - HALF_C;
      end
    end
  end

  assign col_byte = 8'(bus16_i ? (col_adj >> 1) : col_adj);

  assign mask_o[0] = seqin;
  assign mask_o[1] = 1'b1;
  assign mask_o[2] = col_vld_i;
  assign mask_o[3] = page_vld_i;
  assign mask_o[4] = page_vld_i;
  assign mask_o[5] = page_vld_i && (chip_mib_i > 16'(BIG_MIB));

  assign bytes_o[0] = prefix;
  assign bytes_o[1] = cmd_i;
  assign bytes_o[2] = col_byte;
  assign bytes_o[3] = 8'(page_i);
  assign bytes_o[4] = 8'(page_i >> 8);
  assign bytes_o[5] = {4'h0, 4'(page_i >> 16)};

  assign rd_force_o = is_read(cmd_i) && page_vld_i;
  assign nowait_o   = is_nowait(cmd_i);
endmodule

// File: rtl/nand_we_timer.sv
module nand_we_timer #(
  parameter int WE_LOW_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic we_low_o,
  output logic end_o
);
  localparam int          PH_W = $clog2(WE_LOW_CLKS + 2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WE_LOW_CLKS + 1);
  localparam logic [PH_W-1:0] PH_LOW  = PH_W'(WE_LOW_CLKS);

  logic [PH_W-1:0] ph_q;

  // phase 0 setup, 1..WE_LOW_CLKS strobe low, last is hold
  assign we_low_o = run_i && (ph_q != '0) && (ph_q <= PH_LOW);
  assign end_o    = run_i && (ph_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= '0;
    else if (!run_i || end_o)  ph_q <= '0;
    else                       ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int TWB_CLKS   = 10,
  parameter int US_CLKS    = 100,
  parameter int TIMEOUT_US = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic twb_run_i,
  input  logic wait_run_i,
  output logic twb_done_o,
  output logic tmo_o
);
  localparam int TWB_W = $clog2(TWB_CLKS + 1);
  localparam int PRE_W = $clog2(US_CLKS + 1);
  localparam int TMO_W = $clog2(TIMEOUT_US + 1);

  logic [TWB_W-1:0] twb_q;
  logic [PRE_W-1:0] pre_q;
  logic [TMO_W-1:0] us_q;

  assign twb_done_o = twb_run_i && (twb_q == TWB_W'(TWB_CLKS - 1));
  assign tmo_o      = wait_run_i && (us_q == TMO_W'(TIMEOUT_US));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        twb_q <= '0;
    else if (twb_run_i) twb_q <= twb_q + 1'b1;
    else                twb_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (!wait_run_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (pre_q == PRE_W'(US_CLKS - 1)) begin
      pre_q <= '0;
      if (!tmo_o) us_q <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int COL_W       = 10,
  parameter int PAGE_W      = 20,
  parameter int PAGE_BYTES  = 512,
  parameter int WE_LOW_CLKS = 2,
  parameter int TWB_CLKS    = 10,
  parameter int US_CLKS     = 100,
  parameter int TIMEOUT_US  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_cmd_i,
  input  logic              req_col_vld_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_page_vld_i,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic              bus16_i,
  input  logic [15:0]       chip_mib_i,
  input  logic              nand_rb_i,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_nce_o,
  output logic              nand_nwe_o,
  output logic [DATA_W-1:0] nand_io_o,
  output logic              done_o
);
  seq_state_e                  state_q;
  logic [2:0]                  slot_q;
  logic [NUM_SLOTS-1:0]        mask_q;
  logic [NUM_SLOTS-1:0][7:0]   bytes_q;
  logic                        rd_force_q, nowait_q, force_q;

  logic [NUM_SLOTS-1:0]        pl_mask;
  logic [NUM_SLOTS-1:0][7:0]   pl_bytes;
  logic                        pl_rd_force, pl_nowait;
  logic                        we_low, latch_end, twb_done, tmo;
  logic                        nxt_found;
  logic [2:0]                  nxt_slot;
  logic [7:0]                  cur_byte;
  logic                        in_latch;

  nand_addr_plan #(
    .COL_W(COL_W), .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES), .BIG_MIB(32)
  ) u_plan (
    .cmd_i(req_cmd_i), .col_vld_i(req_col_vld_i), .col_i(req_col_i),
    .page_vld_i(req_page_vld_i), .page_i(req_page_i), .bus16_i(bus16_i),
    .chip_mib_i(chip_mib_i), .mask_o(pl_mask), .bytes_o(pl_bytes),
    .rd_force_o(pl_rd_force), .nowait_o(pl_nowait)
  );

  assign in_latch = (state_q == ST_LATCH);

  nand_we_timer #(.WE_LOW_CLKS(WE_LOW_CLKS)) u_we (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_latch),
    .we_low_o(we_low), .end_o(latch_end)
  );

  nand_wait_timer #(
    .TWB_CLKS(TWB_CLKS), .US_CLKS(US_CLKS), .TIMEOUT_US(TIMEOUT_US)
  ) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .twb_run_i(state_q == ST_TWB), .wait_run_i(state_q == ST_WAIT),
    .twb_done_o(twb_done), .tmo_o(tmo)
  );

  // lowest enabled slot above the current one
  always_comb begin
    nxt_found = 1'b0;
    nxt_slot  = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if ((3'(s) > slot_q) && mask_q[s]) begin
        nxt_found = 1'b1;
        nxt_slot  = 3'(s);
      end
    end
  end

  always_comb begin
    case (slot_q)
      3'd0:    cur_byte = bytes_q[0];
      3'd1:    cur_byte = bytes_q[1];
      3'd2:    cur_byte = bytes_q[2];
      3'd3:    cur_byte = bytes_q[3];
      3'd4:    cur_byte = bytes_q[4];
      3'd5:    cur_byte = bytes_q[5];
      default: cur_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      mask_q     <= '0;
      bytes_q    <= '0;
      rd_force_q <= 1'b0;
      nowait_q   <= 1'b0;
      force_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          mask_q     <= pl_mask;
          bytes_q    <= pl_bytes;
          rd_force_q <= pl_rd_force;
          nowait_q   <= pl_nowait;
          slot_q     <= pl_mask[0] ? 3'd0 : 3'd1;
          state_q    <= ST_LATCH;
        end
        ST_LATCH: if (latch_end) begin
          if (nxt_found) begin
            slot_q <= nxt_slot;
            if (rd_force_q && (nxt_slot == 3'(SLOT_PG1))) force_q <= 1'b1;
          end else begin
            state_q <= nowait_q ? ST_DONE : ST_TWB;
          end
        end
        ST_TWB: if (twb_done) state_q <= ST_WAIT;
        ST_WAIT: if (nand_rb_i || (rd_force_q && tmo)) begin
          force_q <= 1'b0;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign nand_cle_o  = in_latch && (slot_q <= 3'd1);
  assign nand_ale_o  = in_latch && (slot_q >= 3'd2);
  assign nand_nwe_o  = !we_low;
  assign nand_nce_o  = !(in_latch || force_q);
  assign nand_io_o   = in_latch ? DATA_W'(cur_byte) : '0;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              nand_cle_o,
  input logic              nand_ale_o,
  input logic              nand_nce_o,
  input logic              nand_nwe_o,
  input logic [DATA_W-1:0] nand_io_o,
  input logic              done_o
);
  p_strobe_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  p_we_has_role_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_nwe_o |-> (nand_cle_o || nand_ale_o));

  p_we_needs_ce_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_nwe_o |-> !nand_nce_o);

  p_we_setup_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_nwe_o) |-> ($stable(nand_io_o) && $stable(nand_cle_o) &&
                           $stable(nand_ale_o) && $past(!nand_nce_o)));

  p_we_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_nwe_o) |-> ($stable(nand_io_o) && $stable(nand_cle_o) &&
                           $stable(nand_ale_o) && !nand_nce_o));

  p_accept_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
  .nand_nce_o(nand_nce_o), .nand_nwe_o(nand_nwe_o), .nand_io_o(nand_io_o),
  .done_o(done_o)
);

// File: tb/nand_cmd_seq_test.sv
`timescale 1ns/1ps
module nand_cmd_seq_test;
  localparam int WEL = 2;
  localparam int TWB = 10;
  localparam int USC = 4;
  localparam int TMO = 30;

  typedef struct packed {
    logic [7:0]  cmd;
    logic        cv;
    logic [9:0]  col;
    logic        pv;
    logic [19:0] page;
    logic        b16;
    logic [15:0] mib;
    logic [2:0]  ncmd;
    logic [2:0]  nb;
    logic [47:0] bytes;
    logic [7:0]  dly;
  } vec_t;

  // R1 R3 R4 R5 R7 R9 vectors
  localparam vec_t VEC [11] = '{
    '{8'h00,1'b1,10'h012,1'b1,20'h03456,1'b0,16'd32, 3'd1,3'd4,48'h00_12_56_34_00_00,8'd12},
    '{8'h80,1'b1,10'h020,1'b1,20'h5ABCD,1'b0,16'd64, 3'd2,3'd6,48'h00_80_20_CD_AB_05,8'd1},
    '{8'h80,1'b1,10'h12C,1'b1,20'h00010,1'b0,16'd32, 3'd2,3'd5,48'h01_80_2C_10_00_00,8'd1},
    '{8'h80,1'b1,10'h208,1'b1,20'h00002,1'b0,16'd32, 3'd2,3'd5,48'h50_80_08_02_00_00,8'd1},
    '{8'h80,1'b1,10'h200,1'b1,20'h00001,1'b0,16'd32, 3'd2,3'd5,48'h50_80_00_01_00_00,8'd1},
    '{8'h80,1'b1,10'h0FF,1'b0,20'h00000,1'b0,16'd32, 3'd2,3'd3,48'h00_80_FF_00_00_00,8'd1},
    '{8'h00,1'b1,10'h040,1'b1,20'h01234,1'b1,16'd128,3'd1,3'd5,48'h00_20_34_12_00_00,8'd12},
    '{8'h60,1'b0,10'h000,1'b1,20'h07788,1'b0,16'd16, 3'd1,3'd3,48'h60_88_77_00_00_00,8'd1},
    '{8'h70,1'b0,10'h000,1'b0,20'h00000,1'b0,16'd32, 3'd1,3'd1,48'h70_00_00_00_00_00,8'd1},
    '{8'h01,1'b1,10'h005,1'b1,20'hF1234,1'b0,16'd33, 3'd1,3'd5,48'h01_05_34_12_0F_00,8'd12},
    '{8'h80,1'b1,10'h12C,1'b1,20'h00003,1'b1,16'd32, 3'd2,3'd5,48'h01_80_16_03_00_00,8'd1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [7:0]  req_cmd_i = '0;
  logic        req_col_vld_i = 1'b0;
  logic [9:0]  req_col_i = '0;
  logic        req_page_vld_i = 1'b0;
  logic [19:0] req_page_i = '0;
  logic        bus16_i = 1'b0;
  logic [15:0] chip_mib_i = 16'd32;
  logic        nand_rb_i = 1'b1;
  logic        nand_cle_o, nand_ale_o, nand_nce_o, nand_nwe_o, done_o;
  logic [15:0] nand_io_o;

  nand_cmd_seq #(
    .DATA_W(16), .COL_W(10), .PAGE_W(20), .PAGE_BYTES(512),
    .WE_LOW_CLKS(WEL), .TWB_CLKS(TWB), .US_CLKS(USC), .TIMEOUT_US(TMO)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o), .req_cmd_i(req_cmd_i),
    .req_col_vld_i(req_col_vld_i), .req_col_i(req_col_i),
    .req_page_vld_i(req_page_vld_i), .req_page_i(req_page_i),
    .bus16_i(bus16_i), .chip_mib_i(chip_mib_i), .nand_rb_i(nand_rb_i),
    .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o), .nand_nce_o(nand_nce_o),
    .nand_nwe_o(nand_nwe_o), .nand_io_o(nand_io_o), .done_o(done_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int cap_n = 0, width_err = 0, done_cnt = 0, done_cyc = 0, last_rise = 0, low_start = 0;
  int cap_byte [8];
  int cap_hi [8];
  bit cap_cle [8];
  bit cap_ale [8];
  bit cap_nce [8];
  bit prev_nwe = 1'b1;

  always @(posedge clk_i) cyc++;

  always @(negedge clk_i) begin
    if (prev_nwe && !nand_nwe_o) begin
      if (cap_n < 8) begin
        cap_byte[cap_n] = int'(nand_io_o[7:0]);
        cap_hi[cap_n]   = int'(nand_io_o[15:8]);
        cap_cle[cap_n]  = nand_cle_o;
        cap_ale[cap_n]  = nand_ale_o;
        cap_nce[cap_n]  = nand_nce_o;
      end
      low_start = cyc;
    end
    if (!prev_nwe && nand_nwe_o) begin
      last_rise = cyc;
      if (cyc - low_start != WEL) width_err++;
      cap_n++;
    end
    if (done_o) begin
      done_cnt++;
      done_cyc = cyc;
    end
    prev_nwe = nand_nwe_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [7:0] c, input logic cv, input logic [9:0] col,
                         input logic pv, input logic [19:0] pg, input logic b16,
                         input logic [15:0] mib);
    int d0;
    int lim;
    d0 = done_cnt;
    cap_n = 0;
    @(negedge clk_i);
    req_cmd_i = c; req_col_vld_i = cv; req_col_i = col;
    req_page_vld_i = pv; req_page_i = pg; bus16_i = b16; chip_mib_i = mib;
    req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lim = 0;
    while (done_cnt == d0 && lim < 5000) begin
      @(negedge clk_i);
      lim++;
    end
    chk(done_cnt == d0 + 1, "R12 request completes with done", done_cnt - d0, 1);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk(req_ready_o == 1'b1, "R12 reset ready", int'(req_ready_o), 1);
    chk(nand_nce_o == 1'b1, "R12 reset nce", int'(nand_nce_o), 1);
    chk(nand_nwe_o == 1'b1, "R12 reset nwe", int'(nand_nwe_o), 1);
    chk(nand_cle_o == 1'b0 && nand_ale_o == 1'b0, "R12 reset cle/ale",
        int'({nand_cle_o, nand_ale_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    nand_rb_i = 1'b1;
    for (int v = 0; v < 11; v++) begin
      run_req(VEC[v].cmd, VEC[v].cv, VEC[v].col, VEC[v].pv, VEC[v].page,
              VEC[v].b16, VEC[v].mib);
      chk(cap_n == int'(VEC[v].nb), $sformatf("R3 R4 byte count vec %0d", v),
          cap_n, int'(VEC[v].nb));
      for (int i = 0; i < int'(VEC[v].nb); i++) begin
        int e;
        e = int'(VEC[v].bytes[47 - 8*i -: 8]);
        chk(cap_byte[i] == e, $sformatf("R1 R3 R4 R5 vec %0d byte %0d", v, i), cap_byte[i], e);
        chk(cap_hi[i] == 0, $sformatf("R5 upper bus vec %0d byte %0d", v, i), cap_hi[i], 0);
        chk(cap_cle[i] == (i < int'(VEC[v].ncmd)) && cap_ale[i] == (i >= int'(VEC[v].ncmd)),
            $sformatf("R2 strobe role vec %0d byte %0d", v, i),
            int'({cap_cle[i], cap_ale[i]}), (i < int'(VEC[v].ncmd)) ? 2 : 1);
        chk(cap_nce[i] == 1'b0, $sformatf("R11 ce low in latch vec %0d", v), int'(cap_nce[i]), 0);
      end
      chk(done_cyc - last_rise == int'(VEC[v].dly), $sformatf("R7 R9 done delay vec %0d", v),
          done_cyc - last_rise, int'(VEC[v].dly));
    end

    // R6 forced chip enable on read, released on ready
    nand_rb_i = 1'b0;
    fork
      run_req(8'h00, 1'b1, 10'h000, 1'b1, 20'h00010, 1'b0, 16'd32);
      begin
        do @(negedge clk_i); while (cap_n < 4);
        repeat (30) @(negedge clk_i);
        chk(nand_nce_o == 1'b0, "R6 ce held low while busy", int'(nand_nce_o), 0);
        chk(req_ready_o == 1'b0, "R12 not ready while busy", int'(req_ready_o), 0);
        nand_rb_i = 1'b1;
      end
    join
    chk(nand_nce_o == 1'b1, "R6 ce released after ready", int'(nand_nce_o), 1);
    chk(done_cyc - last_rise > TWB + 2 && done_cyc - last_rise < TWB + 2 + TMO*USC,
        "R7 wait ended by ready", done_cyc - last_rise, TWB + 33);

    // R8 timeout on read busy
    nand_rb_i = 1'b0;
    run_req(8'h01, 1'b1, 10'h005, 1'b1, 20'h00022, 1'b0, 16'd32);
    chk(done_cyc - last_rise == TWB + 2 + TMO*USC, "R8 timeout delay",
        done_cyc - last_rise, TWB + 2 + TMO*USC);
    chk(nand_nce_o == 1'b1, "R8 ce released on timeout", int'(nand_nce_o), 1);

    // R9 program ignores busy
    run_req(8'h10, 1'b0, 10'h000, 1'b0, 20'h00000, 1'b0, 16'd32);
    chk(done_cyc - last_rise == 1, "R9 program no wait", done_cyc - last_rise, 1);
    chk(cap_n == 1 && cap_byte[0] == 8'h10, "R9 program single byte", cap_byte[0], 8'h10);

    // R10 reset waits past timeout length
    begin
      int d1;
      d1 = done_cnt;
      fork
        run_req(8'hFF, 1'b0, 10'h000, 1'b0, 20'h00000, 1'b0, 16'd32);
        begin
          repeat (300) @(negedge clk_i);
          chk(done_cnt == d1, "R10 reset no timeout", done_cnt - d1, 0);
          chk(nand_nce_o == 1'b1, "R6 ce not forced for reset", int'(nand_nce_o), 1);
          nand_rb_i = 1'b1;
        end
      join
      chk(done_cnt == d1 + 1, "R10 reset ends on ready", done_cnt - d1, 1);
    end

    chk(width_err == 0, "R11 nwe low width", width_err, 0);
    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule